// File: doc/BRIEF.md
# Debug Transfer Mailbox

This block sits between a console-side command port and a host-side link controller and coordinates bulk debug transfers in both directions. The console issues small numbered sub-commands, each with one 32-bit argument. Each sub-command gets back a 32-bit result word and an error flag. The block keeps two one-deep transfer slots. The console-to-host slot holds a source address and a length behind a pending flag. The host-to-console slot holds the host's argument, the host's length and a console-chosen destination address behind a ready flag.

A small sequencer shares one external DMA engine between the two slots. It launches a console-to-host copy once the host link is quiet and the engine is free. When the host announces data, the sequencer raises a waiting indication toward the console. It then runs the host-to-console copy once the console has supplied a destination. A sub-command that would overwrite an occupied slot is refused at once with the error flag. The command port never stalls.

Top module: `dbg_xfer_mailbox`

## Requirements
- R1: Sub-command code 0 stores its argument as the console-to-host source address when the pending flag is clear and answers with result 0 and no error. When the pending flag is set it answers with error 1 and result 0 and stores nothing.
- R2: Sub-command code 1 stores its argument as the console-to-host length and sets the pending flag when pending is clear. When pending is already set it answers with error 1 and leaves the slot unchanged.
- R3: Sub-command code 2 answers with the pending flag in result bit 0, all other result bits 0, and no error.
- R4: Sub-command codes 3 and 4 answer, without error, with the argument word and the length most recently latched from a host announcement (both 0 after reset).
- R5: Sub-command code 5 stores its argument as the host-to-console destination, sets the ready flag and clears the waiting indication when ready is clear. When ready is already set it answers with error 1 and changes nothing.
- R6: Any sub-command code above 5 answers with error 1 and result 0 and changes no state.
- R7: A command is taken on a clock edge where cmd_valid is high and cmd_ack is low. cmd_ack is high for exactly the following cycle, with rsp_data and rsp_err valid in that cycle. The response registers hold their values until the next command is taken.
- R8: A one-cycle hx_announce seen while the sequencer is idle latches hx_arg and hx_len and sets host_waiting on that edge. An announcement seen while a transfer is in progress or awaiting its destination is ignored.
- R9: In the idle sequencer, with pending set, link_idle high and dma_busy low, dma_start pulses for one cycle with dma_dir 0 and dma_addr/dma_len equal to the stored source address and length. The pending flag clears on the edge where dma_done is seen for that copy.
- R10: After an announcement, dma_start pulses with dma_dir 1, dma_addr equal to the destination and dma_len equal to the host length, only once ready is set and dma_busy is low. The ready flag clears on the edge where dma_done is seen for that copy.
- R11: When an announcement and a launchable console-to-host transfer occur in the same idle cycle, the announcement is taken and the console-to-host copy waits.
- R12: Reset (rst_n low) clears pending, ready, host_waiting, cmd_ack and dma_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Console command request, held until acknowledged |
| cmd_code | input | 8 | Sub-command number |
| cmd_arg | input | 32 | Sub-command argument |
| cmd_ack | output | 1 | One-cycle acknowledge, response valid |
| rsp_data | output | 32 | Result word |
| rsp_err | output | 1 | Error flag of the response |
| hx_announce | input | 1 | Host announces a host-to-console transfer (one cycle) |
| hx_arg | input | 32 | Host-supplied argument word |
| hx_len | input | 32 | Host-supplied length |
| host_waiting | output | 1 | Host data is waiting for a console destination |
| link_idle | input | 1 | Host link controller is not busy with a command |
| dma_busy | input | 1 | DMA engine is busy |
| dma_done | input | 1 | DMA engine finished the current copy (one cycle) |
| dma_start | output | 1 | One-cycle DMA launch strobe |
| dma_dir | output | 1 | 0 memory-to-host, 1 host-to-memory |
| dma_addr | output | 32 | DMA memory address |
| dma_len | output | 32 | DMA length |
| c2h_pending | output | 1 | Console-to-host slot occupied |
| h2c_ready | output | 1 | Host-to-console destination supplied |

## Verification
The hardest case is a collision between the two directions. A pending console-to-host copy and a host announcement must meet in the same idle cycle, and a slot-filling command must land on the cycle the DMA reports completion. The bench fills the console-to-host slot while link_idle is held low. It then releases link_idle and pulses the announcement on the same edge to force the priority case. A long random phase follows, with random codes, link activity and announcements against a DMA responder. It compares every output against a behavioural model on every cycle, which sweeps the done-versus-command coincidences.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] SUB_C2H_ADDR = 8'd0;
  localparam logic [CODE_W-1:0] SUB_C2H_LEN  = 8'd1;
  localparam logic [CODE_W-1:0] SUB_C2H_STAT = 8'd2;
  localparam logic [CODE_W-1:0] SUB_H2C_ARG  = 8'd3;
  localparam logic [CODE_W-1:0] SUB_H2C_LEN  = 8'd4;
  localparam logic [CODE_W-1:0] SUB_H2C_DEST = 8'd5;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_C2H_RUN,
    SEQ_H2C_WAIT,
    SEQ_H2C_RUN
  } seq_state_t;

  // A command is refused when its code is unknown or its slot is occupied.
  function automatic logic mbx_refused(logic [CODE_W-1:0] code, logic pend, logic rdy);
    case (code)
      SUB_C2H_ADDR, SUB_C2H_LEN: return pend;
      SUB_C2H_STAT, SUB_H2C_ARG, SUB_H2C_LEN: return 1'b0;
      SUB_H2C_DEST: return rdy;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/mbx_cmd_port.sv
module mbx_cmd_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] cmd_arg,
  input  logic [DATA_W-1:0] host_arg,
  input  logic [DATA_W-1:0] host_len,
  input  logic              c2h_clear,
  input  logic              h2c_clear,
  output logic              cmd_ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              c2h_pending,
  output logic              h2c_ready,
  output logic [DATA_W-1:0] c2h_addr,
  output logic [DATA_W-1:0] c2h_len,
  output logic [DATA_W-1:0] h2c_dest,
  output logic              h2c_arm,
  output logic              cmd_accept
);

  logic              refuse;
  logic              set_pend;
  logic              store_addr;
  logic [DATA_W-1:0] result;

  always_comb begin
    cmd_accept = cmd_valid && !cmd_ack;
    refuse     = mbx_refused(cmd_code, c2h_pending, h2c_ready);
    store_addr = cmd_accept && !refuse && (cmd_code == SUB_C2H_ADDR);
    set_pend   = cmd_accept && !refuse && (cmd_code == SUB_C2H_LEN);
    h2c_arm    = cmd_accept && !refuse && (cmd_code == SUB_H2C_DEST);
  end

  always_comb begin
    result = '0;
    if (!refuse) begin
      case (cmd_code)
        SUB_C2H_STAT: result = {{(DATA_W-1){1'b0}}, c2h_pending};
        SUB_H2C_ARG:  result = host_arg;
        SUB_H2C_LEN:  result = host_len;
        default:      result = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ack     <= 1'b0;
      rsp_data    <= '0;
      rsp_err     <= 1'b0;
      c2h_pending <= 1'b0;
      h2c_ready   <= 1'b0;
      c2h_addr    <= '0;
      c2h_len     <= '0;
      h2c_dest    <= '0;
    end else begin
      cmd_ack <= cmd_accept;
      if (cmd_accept) begin
        rsp_data <= result;
        rsp_err  <= refuse;
      end
      if (store_addr) c2h_addr <= cmd_arg;
      if (set_pend)   c2h_len  <= cmd_arg;
      if (h2c_arm)    h2c_dest <= cmd_arg;
      if (set_pend)       c2h_pending <= 1'b1;
      else if (c2h_clear) c2h_pending <= 1'b0;
      if (h2c_arm)        h2c_ready <= 1'b1;
      else if (h2c_clear) h2c_ready <= 1'b0;
    end
  end

endmodule

// File: rtl/mbx_xfer_seq.sv
module mbx_xfer_seq
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hx_announce,
  input  logic [DATA_W-1:0] hx_arg,
  input  logic [DATA_W-1:0] hx_len,
  input  logic              link_idle,
  input  logic              dma_busy,
  input  logic              dma_done,
  input  logic              c2h_pending,
  input  logic              h2c_ready,
  input  logic [DATA_W-1:0] c2h_addr,
  input  logic [DATA_W-1:0] c2h_len,
  input  logic [DATA_W-1:0] h2c_dest,
  input  logic              h2c_arm,
  output logic              host_waiting,
  output logic [DATA_W-1:0] host_arg,
  output logic [DATA_W-1:0] host_len,
  output logic              dma_start,
  output logic              dma_dir,
  output logic [DATA_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_len,
  output logic              c2h_clear,
  output logic              h2c_clear
);

  seq_state_t state;
  logic take_announce;
  logic launch_c2h;
  logic launch_h2c;

  always_comb begin
    take_announce = (state == SEQ_IDLE) && hx_announce;
    launch_c2h    = (state == SEQ_IDLE) && !hx_announce && c2h_pending
                    && link_idle && !dma_busy;
    launch_h2c    = (state == SEQ_H2C_WAIT) && h2c_ready && !dma_busy;
    c2h_clear     = (state == SEQ_C2H_RUN) && dma_done;
    h2c_clear     = (state == SEQ_H2C_RUN) && dma_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      host_waiting <= 1'b0;
      host_arg     <= '0;
      host_len     <= '0;
      dma_start    <= 1'b0;
      dma_dir      <= 1'b0;
      dma_addr     <= '0;
      dma_len      <= '0;
    end else begin
      dma_start <= 1'b0;
      if (take_announce)  host_waiting <= 1'b1;
      else if (h2c_arm)   host_waiting <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (take_announce) begin
            host_arg <= hx_arg;
            host_len <= hx_len;
            state    <= SEQ_H2C_WAIT;
          end else if (launch_c2h) begin
            dma_start <= 1'b1;
            dma_dir   <= 1'b0;
            dma_addr  <= c2h_addr;
            dma_len   <= c2h_len;
            state     <= SEQ_C2H_RUN;
          end
        end
        SEQ_C2H_RUN:  if (c2h_clear) state <= SEQ_IDLE;
        SEQ_H2C_WAIT: begin
          if (launch_h2c) begin
            dma_start <= 1'b1;
            dma_dir   <= 1'b1;
            dma_addr  <= h2c_dest;
            dma_len   <= host_len;
            state     <= SEQ_H2C_RUN;
          end
        end
        SEQ_H2C_RUN:  if (h2c_clear) state <= SEQ_IDLE;
        default:      state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dbg_xfer_mailbox.sv
module dbg_xfer_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              cmd_ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic              hx_announce,
  input  logic [DATA_W-1:0] hx_arg,
  input  logic [DATA_W-1:0] hx_len,
  output logic              host_waiting,
  input  logic              link_idle,
  input  logic              dma_busy,
  input  logic              dma_done,
  output logic              dma_start,
  output logic              dma_dir,
  output logic [DATA_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_len,
  output logic              c2h_pending,
  output logic              h2c_ready
);

  logic [DATA_W-1:0] host_arg;
  logic [DATA_W-1:0] host_len;
  logic [DATA_W-1:0] c2h_addr;
  logic [DATA_W-1:0] c2h_len;
  logic [DATA_W-1:0] h2c_dest;
  logic              c2h_clear;
  logic              h2c_clear;
  logic              h2c_arm;
  logic              cmd_accept;

  mbx_cmd_port #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .host_arg(host_arg), .host_len(host_len),
    .c2h_clear(c2h_clear), .h2c_clear(h2c_clear),
    .cmd_ack(cmd_ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .c2h_pending(c2h_pending), .h2c_ready(h2c_ready),
    .c2h_addr(c2h_addr), .c2h_len(c2h_len), .h2c_dest(h2c_dest),
    .h2c_arm(h2c_arm), .cmd_accept(cmd_accept)
  );

  mbx_xfer_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .hx_announce(hx_announce), .hx_arg(hx_arg), .hx_len(hx_len),
    .link_idle(link_idle), .dma_busy(dma_busy), .dma_done(dma_done),
    .c2h_pending(c2h_pending), .h2c_ready(h2c_ready),
    .c2h_addr(c2h_addr), .c2h_len(c2h_len), .h2c_dest(h2c_dest),
    .h2c_arm(h2c_arm),
    .host_waiting(host_waiting), .host_arg(host_arg), .host_len(host_len),
    .dma_start(dma_start), .dma_dir(dma_dir),
    .dma_addr(dma_addr), .dma_len(dma_len),
    .c2h_clear(c2h_clear), .h2c_clear(h2c_clear)
  );

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_accept,
  input logic [7:0] cmd_code,
  input logic       cmd_ack,
  input logic       rsp_err,
  input logic       hx_announce,
  input logic       link_idle,
  input logic       dma_busy,
  input logic       dma_done,
  input logic       dma_start,
  input logic       dma_dir,
  input logic       c2h_pending,
  input logic       h2c_ready,
  input logic       host_waiting
);

  a_r7_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> cmd_ack);

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack);

  a_r6_unknown_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_code > 8'd5) |=> rsp_err);

  a_r2_pending_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c2h_pending) |-> $past(cmd_accept && cmd_code == 8'd1));

  a_r9_pending_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c2h_pending) |-> $past(dma_done));

  a_r10_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h2c_ready) |-> $past(dma_done));

  a_r5_waiting_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_waiting) |-> $past(cmd_accept && cmd_code == 8'd5));

  a_r8_waiting_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_waiting) |-> $past(hx_announce));

  a_r9_c2h_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_start && !dma_dir) |-> $past(link_idle && !dma_busy && c2h_pending));

  a_r10_h2c_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_start && dma_dir) |-> $past(h2c_ready && !dma_busy));

  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

endmodule

bind dbg_xfer_mailbox mbx_checker u_mbx_chk (
  .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .cmd_code(cmd_code),
  .cmd_ack(cmd_ack), .rsp_err(rsp_err), .hx_announce(hx_announce),
  .link_idle(link_idle), .dma_busy(dma_busy), .dma_done(dma_done),
  .dma_start(dma_start), .dma_dir(dma_dir), .c2h_pending(c2h_pending),
  .h2c_ready(h2c_ready), .host_waiting(host_waiting)
);

// File: tb/dbg_xfer_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_xfer_mailbox_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_ack;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        hx_announce = 1'b0;
  logic [31:0] hx_arg = '0;
  logic [31:0] hx_len = '0;
  logic        host_waiting;
  logic        link_idle = 1'b1;
  logic        dma_busy = 1'b0;
  logic        dma_done = 1'b0;
  logic        dma_start;
  logic        dma_dir;
  logic [31:0] dma_addr;
  logic [31:0] dma_len;
  logic        c2h_pending;
  logic        h2c_ready;

  always #2.5 clk = ~clk;

  dbg_xfer_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_arg(cmd_arg), .cmd_ack(cmd_ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .hx_announce(hx_announce), .hx_arg(hx_arg), .hx_len(hx_len),
    .host_waiting(host_waiting), .link_idle(link_idle), .dma_busy(dma_busy),
    .dma_done(dma_done), .dma_start(dma_start), .dma_dir(dma_dir),
    .dma_addr(dma_addr), .dma_len(dma_len), .c2h_pending(c2h_pending),
    .h2c_ready(h2c_ready)
  );

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  int dma_lat = 3;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // Behavioural reference model
  bit        m_ack, m_err, m_pend, m_rdy, m_wait, m_start, m_dir;
  bit [31:0] m_data, m_addr, m_len, m_src, m_slen, m_harg, m_hlen, m_dst;
  int        m_phase; // 0 idle, 1 outbound copy, 2 awaiting destination, 3 inbound copy

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack = 0; m_err = 0; m_pend = 0; m_rdy = 0; m_wait = 0; m_start = 0; m_dir = 0;
      m_data = 0; m_addr = 0; m_len = 0; m_src = 0; m_slen = 0;
      m_harg = 0; m_hlen = 0; m_dst = 0; m_phase = 0;
    end else begin
      bit take, refuse, n_pend, n_rdy, arm;
      int n_phase;
      bit [31:0] res;
      take = cmd_valid && !m_ack;
      n_pend = m_pend; n_rdy = m_rdy; arm = 0; n_phase = m_phase;
      refuse = 0; res = 0;
      if (take) begin
        if (cmd_code == 0) begin
          if (m_pend) refuse = 1; else m_src = cmd_arg;
        end else if (cmd_code == 1) begin
          if (m_pend) refuse = 1; else begin m_slen = cmd_arg; n_pend = 1; end
        end else if (cmd_code == 2) res = {31'd0, m_pend};
        else if (cmd_code == 3) res = m_harg;
        else if (cmd_code == 4) res = m_hlen;
        else if (cmd_code == 5) begin
          if (m_rdy) refuse = 1; else begin m_dst = cmd_arg; n_rdy = 1; arm = 1; end
        end else refuse = 1;
        m_data = refuse ? 32'd0 : res;
        m_err = refuse;
      end
      m_ack = take;
      m_start = 0;
      if (m_phase == 0) begin
        if (hx_announce) begin
          m_harg = hx_arg; m_hlen = hx_len; n_phase = 2;
        end else if (m_pend && link_idle && !dma_busy) begin
          m_start = 1; m_dir = 0; m_addr = m_src; m_len = m_slen; n_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (dma_done) begin n_phase = 0; n_pend = 0; end
      end else if (m_phase == 2) begin
        if (m_rdy && !dma_busy) begin
          m_start = 1; m_dir = 1; m_addr = m_dst; m_len = m_hlen; n_phase = 3;
        end
      end else begin
        if (dma_done) begin n_phase = 0; n_rdy = 0; end
      end
      if (m_phase == 0 && hx_announce) m_wait = 1;
      else if (arm) m_wait = 0;
      m_pend = n_pend; m_rdy = n_rdy; m_phase = n_phase;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 ack", {31'd0, cmd_ack}, {31'd0, m_ack});
      chk("R7 rsp_data", rsp_data, m_data);
      chk("R7 rsp_err", {31'd0, rsp_err}, {31'd0, m_err});
      chk("R2 pending", {31'd0, c2h_pending}, {31'd0, m_pend});
      chk("R5 ready", {31'd0, h2c_ready}, {31'd0, m_rdy});
      chk("R8 waiting", {31'd0, host_waiting}, {31'd0, m_wait});
      chk("R9 dma_start", {31'd0, dma_start}, {31'd0, m_start});
      chk("R10 dma_dir", {31'd0, dma_dir}, {31'd0, m_dir});
      chk("R9 dma_addr", dma_addr, m_addr);
      chk("R9 dma_len", dma_len, m_len);
    end
  end

  // DMA responder
  always begin
    @(negedge clk);
    if (rst_n && dma_start) begin
      dma_busy = 1'b1;
      repeat (dma_lat) @(negedge clk);
      dma_done = 1'b1;
      dma_busy = 1'b0;
      @(negedge clk);
      dma_done = 1'b0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic send(logic [7:0] code, logic [31:0] arg,
                      logic [31:0] exp_data, logic exp_err, string tag);
    cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
    @(posedge clk); @(negedge clk);
    chk({tag, " ack"}, {31'd0, cmd_ack}, 32'd1);
    chk({tag, " data"}, rsp_data, exp_data);
    chk({tag, " err"}, {31'd0, rsp_err}, {31'd0, exp_err});
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic announce(logic [31:0] a, logic [31:0] l);
    hx_announce = 1'b1; hx_arg = a; hx_len = l;
    @(posedge clk); @(negedge clk);
    hx_announce = 1'b0;
  endtask

  task automatic expect_start(logic dir, logic [31:0] addr, logic [31:0] len, string tag);
    int n = 0;
    while (!dma_start && n < 60) begin @(negedge clk); n++; end
    chk({tag, " start seen"}, {31'd0, dma_start}, 32'd1);
    chk({tag, " dir"}, {31'd0, dma_dir}, {31'd0, dir});
    chk({tag, " addr"}, dma_addr, addr);
    chk({tag, " len"}, dma_len, len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12 pending", {31'd0, c2h_pending}, 32'd0);
    chk("R12 ready", {31'd0, h2c_ready}, 32'd0);
    chk("R12 waiting", {31'd0, host_waiting}, 32'd0);
    chk("R12 ack", {31'd0, cmd_ack}, 32'd0);
    chk("R12 dma_start", {31'd0, dma_start}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send(8'd2, 32'h0, 32'd0, 1'b0, "R3 idle status");
    send(8'd7, 32'h55, 32'd0, 1'b1, "R6 code 7");
    send(8'd200, 32'h55, 32'd0, 1'b1, "R6 code 200");
    send(8'd3, 32'h0, 32'd0, 1'b0, "R4 arg after reset");
    send(8'd4, 32'h0, 32'd0, 1'b0, "R4 len after reset");

    // Outbound slot, held off by a busy link
    link_idle = 1'b0;
    send(8'd0, 32'h0000_1000, 32'd0, 1'b0, "R1 addr store");
    send(8'd1, 32'h0000_0040, 32'd0, 1'b0, "R2 len store");
    chk("R2 pending set", {31'd0, c2h_pending}, 32'd1);
    send(8'd2, 32'h0, 32'd1, 1'b0, "R3 pending status");
    send(8'd0, 32'hDEAD_0000, 32'd0, 1'b1, "R1 refused");
    send(8'd1, 32'h0000_0099, 32'd0, 1'b1, "R2 refused");
    send(8'd9, 32'h0, 32'd0, 1'b1, "R6 no change");
    repeat (5) begin
      @(negedge clk);
      chk("R9 held by link", {31'd0, dma_start}, 32'd0);
    end
    link_idle = 1'b1;
    expect_start(1'b0, 32'h0000_1000, 32'h0000_0040, "R9 outbound");
    repeat (dma_lat + 3) @(negedge clk);
    chk("R9 pending cleared", {31'd0, c2h_pending}, 32'd0);

    // Inbound transfer
    announce(32'h0000_CAFE, 32'h0000_0080);
    chk("R8 waiting set", {31'd0, host_waiting}, 32'd1);
    send(8'd3, 32'h0, 32'h0000_CAFE, 1'b0, "R4 host arg");
    send(8'd4, 32'h0, 32'h0000_0080, 1'b0, "R4 host len");
    chk("R10 no start before ready", {31'd0, dma_start}, 32'd0);
    cmd_valid = 1'b1; cmd_code = 8'd5; cmd_arg = 32'h0000_2000;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 ready set", {31'd0, h2c_ready}, 32'd1);
    chk("R5 waiting cleared", {31'd0, host_waiting}, 32'd0);
    chk("R5 accepted", {31'd0, rsp_err}, 32'd0);
    expect_start(1'b1, 32'h0000_2000, 32'h0000_0080, "R10 inbound");
    @(negedge clk);
    send(8'd5, 32'h0000_3000, 32'd0, 1'b1, "R5 refused while ready");
    announce(32'h1111_1111, 32'h2222_2222);
    chk("R8 ignored while busy", {31'd0, host_waiting}, 32'd0);
    repeat (dma_lat + 3) @(negedge clk);
    chk("R10 ready cleared", {31'd0, h2c_ready}, 32'd0);
    send(8'd3, 32'h0, 32'h0000_CAFE, 1'b0, "R8 ignored arg kept");

    // Priority: announcement and launchable outbound copy in one cycle
    link_idle = 1'b0;
    send(8'd0, 32'h0000_4000, 32'd0, 1'b0, "R11 addr");
    send(8'd1, 32'h0000_0010, 32'd0, 1'b0, "R11 len");
    link_idle = 1'b1;
    announce(32'h0000_0A0A, 32'h0000_0020);
    chk("R11 announcement taken", {31'd0, host_waiting}, 32'd1);
    chk("R11 outbound deferred", {31'd0, dma_start}, 32'd0);
    send(8'd5, 32'h0000_5000, 32'd0, 1'b0, "R11 dest");
    expect_start(1'b1, 32'h0000_5000, 32'h0000_0020, "R11 inbound first");
    @(negedge clk);
    expect_start(1'b0, 32'h0000_4000, 32'h0000_0010, "R11 outbound after");
    repeat (dma_lat + 3) @(negedge clk);
    chk("R11 both slots free", {30'd0, c2h_pending, h2c_ready}, 32'd0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (cmd_valid && cmd_ack) cmd_valid = 1'b0;
      else if (!cmd_valid && ($urandom % 3 == 0)) begin
        cmd_valid = 1'b1;
        cmd_code = 8'($urandom % 8);
        cmd_arg = $urandom;
      end
      link_idle = ($urandom % 4) != 0;
      hx_announce = ($urandom % 16) == 0;
      hx_arg = $urandom; hx_len = $urandom;
      dma_lat = 1 + ($urandom % 4);
      @(negedge clk);
    end
    cmd_valid = 1'b0; hx_announce = 1'b0;
    repeat (20) @(negedge clk);

    // R12: reset mid-activity
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R12 pending after reset", {31'd0, c2h_pending}, 32'd0);
    chk("R12 ready after reset", {31'd0, h2c_ready}, 32'd0);
    chk("R12 waiting after reset", {31'd0, host_waiting}, 32'd0);
    finish_run();
  end

endmodule